// File: doc/BRIEF.md
# System Event Status and Bus-Error Register

This block is a 32-bit memory-mapped control word that records system events as sticky flags and decides which of those events should also abort the current access with an internal bus error. It watches four event sources. The first is an unmasked interrupt request from the core. The second is a timeout strobe from an external watchdog counter. The third and fourth come from each bus cycle's chip-select picture. For each cycle the block receives which chip-select lines are trying to assert and which of those regions are marked read-only. From these it works out for itself whether the cycle is a write-protect violation or an address-decode conflict.

Software reads the flags at any time through a simple register port. It clears flags by writing ones to them, and zeros leave flags alone. A single enable bit in the same word chooses whether a write-protect violation also produces a bus error. A watchdog timeout always produces one. The bus-error output is a registered single-clock pulse. It is asserted on the clock after the causing event.

Top module: `sysEventReg`

## Requirements
- R1: When `regSel` is high, `regRdData` shows the flags at bits 27 (interrupt active), 26 (watchdog timeout), 25 (write-protect violation) and 24 (decode conflict), and the protect-error enable at bit 8. When `regSel` is low, `regRdData` is zero.
- R2: A register write with `regByteEn[3]` high clears each flag whose bit in `regWrData[27:24]` is one and leaves flags with a zero bit unchanged. Several flags may clear in one write. With `regByteEn[3]` low the flags are untouched.
- R3: An active-low reset on `rstN` clears all four flags, the enable bit and `busErrOut`.
- R4: A cycle with `irqPendingIn` high sets the interrupt-active flag (bit 27) at the next clock.
- R5: A cycle with `wdogTimeoutIn` high sets the watchdog flag (bit 26) and pulses `busErrOut` on the next clock, even when the flag is already set.
- R6: A cycle with `busCycleIn` and `busWriteIn` high, and any line active in both `csActiveIn` and `csReadOnlyIn`, sets the write-protect flag (bit 25) whatever the enable holds. Read cycles never set it.
- R7: A write-protect violation pulses `busErrOut` on the next clock only if the enable bit (bit 8) is one. `busErrOut` is high exactly in the cycles after a timeout or an enabled violation.
- R8: A cycle with `busCycleIn` high and two or more bits of `csActiveIn` set raises the decode-conflict flag (bit 24). One or zero active lines, or no bus cycle, leave it alone.
- R9: When a hardware set and a write-one-to-clear reach the same flag in the same clock, the flag ends up set.
- R10: All bits other than 27:24 and 8 read as zero, and writes to them have no effect. The enable bit loads from `regWrData[8]` only when `regByteEn[1]` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPendingIn | input | 1 | Core has an unmasked interrupt request |
| wdogTimeoutIn | input | 1 | Watchdog interval expired this cycle |
| busCycleIn | input | 1 | A bus cycle is being decoded this clock |
| busWriteIn | input | 1 | The current bus cycle is a write |
| csActiveIn | input | 4 | Chip-select lines trying to assert |
| csReadOnlyIn | input | 4 | Per-region read-only attribute |
| regSel | input | 1 | Register access selected |
| regWrEn | input | 1 | Access is a write |
| regByteEn | input | 4 | Byte lanes written |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data |
| busErrOut | output | 1 | One-clock internal bus-error pulse |

## Verification
The bench targets the collisions between hardware and software. These are an interrupt arriving in the same clock as a clear of its flag, where a design that let the clear win would lose the event, and a clear write with the top byte lane disabled, which a design ignoring lane enables would wrongly obey. It repeats a watchdog timeout while the flag is already set, where a design gating the error on the flag's rising edge would stay silent. It also triggers write-protect violations with the enable both clear and set, which catches a design that ties the flag to the enable or raises errors regardless. Chip-select vectors with exactly one, exactly two and all lines active, with and without a bus cycle and on read versus write cycles, test the population-count threshold and the qualifiers. An off-by-one threshold or a missing qualifier shows up there as a spurious or missing conflict or protect flag.

// File: rtl/sysEventPkg.sv
package sysEventPkg;

  // Number of sticky event flags held in the register
  localparam int FLAG_CNT = 4;

  // Position of each event inside the flag field (bit order is behaviour)
  localparam int IDX_CONFLICT = 0;
  localparam int IDX_PROTECT  = 1;
  localparam int IDX_WDOG     = 2;
  localparam int IDX_IRQ      = 3;

  // Strobes the control half hands to the storage half every clock
  typedef struct packed {
    logic [FLAG_CNT-1:0] setMask;     // hardware events recognised this clock
    logic [FLAG_CNT-1:0] clrMask;     // software write-one-to-clear bits
    logic                enLoad;      // enable bit is being written
    logic                enValue;     // value written to the enable bit
    logic                raiseBusErr; // bus error due next clock
  } ctrlStrobes_t;

endpackage

// File: rtl/sysEventCtrl.sv
module sysEventCtrl
  import sysEventPkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int BYTE_CNT = 4,
  parameter int STAT_LANE = 3,
  parameter int EN_LANE  = 1
) (
  input  logic                irqPendingIn,
  input  logic                wdogTimeoutIn,
  input  logic                busCycleIn,
  input  logic                busWriteIn,
  input  logic [NUM_CS-1:0]   csActiveIn,
  input  logic [NUM_CS-1:0]   csReadOnlyIn,
  input  logic                regSel,
  input  logic                regWrEn,
  input  logic [BYTE_CNT-1:0] regByteEn,
  input  logic [FLAG_CNT-1:0] clrBits,
  input  logic                enBit,
  input  logic                wpvEnable,
  output ctrlStrobes_t        strobes
);

  localparam int CNT_W = $clog2(NUM_CS + 1);

  logic [CNT_W-1:0] csCount;
  logic             decodeConflict;
  logic             protectViolation;
  logic             regWrite;

  // Population count of the chip-select lines asserting this cycle
  always_comb begin
    csCount = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      csCount = csCount + CNT_W'(csActiveIn[i]);
    end
  end

  assign decodeConflict   = busCycleIn && (csCount >= CNT_W'(2));
  assign protectViolation = busCycleIn && busWriteIn &&
                            (|(csActiveIn & csReadOnlyIn));
  assign regWrite         = regSel && regWrEn;

  always_comb begin
    strobes = '0;
    strobes.setMask[IDX_IRQ]      = irqPendingIn;
    strobes.setMask[IDX_WDOG]     = wdogTimeoutIn;
    strobes.setMask[IDX_PROTECT]  = protectViolation;
    strobes.setMask[IDX_CONFLICT] = decodeConflict;
    if (regWrite && regByteEn[STAT_LANE]) begin
      strobes.clrMask = clrBits;
    end
    strobes.enLoad      = regWrite && regByteEn[EN_LANE];
    strobes.enValue     = enBit;
    strobes.raiseBusErr = wdogTimeoutIn || (protectViolation && wpvEnable);
  end

endmodule

// File: rtl/sysEventDatapath.sv
module sysEventDatapath
  import sysEventPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STAT_LSB = 24,
  parameter int EN_BIT   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                regSel,
  output logic [DATA_W-1:0]   regRdData,
  output logic [FLAG_CNT-1:0] statusFlags,
  output logic                wpvEnable,
  output logic                busErrOut
);

  logic [FLAG_CNT-1:0] flagsQ;
  logic                enQ;
  logic                berrQ;
  logic [DATA_W-1:0]   wordView;

  // Set beats clear: an event in the same clock as its clear survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      enQ    <= 1'b0;
      berrQ  <= 1'b0;
    end else begin
      flagsQ <= (flagsQ & ~strobes.clrMask) | strobes.setMask;
      if (strobes.enLoad) begin
        enQ <= strobes.enValue;
      end
      berrQ <= strobes.raiseBusErr;
    end
  end

  always_comb begin
    wordView = '0;
    wordView[STAT_LSB +: FLAG_CNT] = flagsQ;
    wordView[EN_BIT] = enQ;
  end

  assign regRdData   = regSel ? wordView : '0;
  assign statusFlags = flagsQ;
  assign wpvEnable   = enQ;
  assign busErrOut   = berrQ;

endmodule

// File: rtl/sysEventReg.sv
module sysEventReg
  import sysEventPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_CS   = 4,
  parameter int STAT_LSB = 24,
  parameter int EN_BIT   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 irqPendingIn,
  input  logic                 wdogTimeoutIn,
  input  logic                 busCycleIn,
  input  logic                 busWriteIn,
  input  logic [NUM_CS-1:0]    csActiveIn,
  input  logic [NUM_CS-1:0]    csReadOnlyIn,
  input  logic                 regSel,
  input  logic                 regWrEn,
  input  logic [DATA_W/8-1:0]  regByteEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 busErrOut
);

  localparam int BYTE_CNT  = DATA_W / 8;
  localparam int STAT_LANE = STAT_LSB / 8;
  localparam int EN_LANE   = EN_BIT / 8;

  ctrlStrobes_t        strobes;
  logic [FLAG_CNT-1:0] statusFlags;
  logic                wpvEnable;
  logic                unusedWrBits;

  // Write data outside the implemented fields has no destination
  assign unusedWrBits = ^regWrData;

  sysEventCtrl #(
    .NUM_CS   (NUM_CS),
    .BYTE_CNT (BYTE_CNT),
    .STAT_LANE(STAT_LANE),
    .EN_LANE  (EN_LANE)
  ) i_ctrl (
    .irqPendingIn (irqPendingIn),
    .wdogTimeoutIn(wdogTimeoutIn),
    .busCycleIn   (busCycleIn),
    .busWriteIn   (busWriteIn),
    .csActiveIn   (csActiveIn),
    .csReadOnlyIn (csReadOnlyIn),
    .regSel       (regSel),
    .regWrEn      (regWrEn),
    .regByteEn    (regByteEn),
    .clrBits      (regWrData[STAT_LSB +: FLAG_CNT]),
    .enBit        (regWrData[EN_BIT]),
    .wpvEnable    (wpvEnable),
    .strobes      (strobes)
  );

  sysEventDatapath #(
    .DATA_W  (DATA_W),
    .STAT_LSB(STAT_LSB),
    .EN_BIT  (EN_BIT)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regSel     (regSel),
    .regRdData  (regRdData),
    .statusFlags(statusFlags),
    .wpvEnable  (wpvEnable),
    .busErrOut  (busErrOut)
  );

endmodule

// File: rtl/sysEventRegChk.sv
module sysEventRegChk #(
  parameter int DATA_W   = 32,
  parameter int NUM_CS   = 4,
  parameter int STAT_LSB = 24,
  parameter int EN_BIT   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                irqPendingIn,
  input logic                wdogTimeoutIn,
  input logic                busCycleIn,
  input logic                busWriteIn,
  input logic [NUM_CS-1:0]   csActiveIn,
  input logic [NUM_CS-1:0]   csReadOnlyIn,
  input logic                regSel,
  input logic                regWrEn,
  input logic [DATA_W/8-1:0] regByteEn,
  input logic [DATA_W-1:0]   regWrData,
  input logic [DATA_W-1:0]   regRdData,
  input logic                busErrOut,
  input logic [3:0]          statusFlags,
  input logic                wpvEnable
);

  localparam int STAT_LANE = STAT_LSB / 8;

  logic [DATA_W-1:0] liveMask;
  logic              violNow;

  always_comb begin
    liveMask = '0;
    liveMask[STAT_LSB +: 4] = 4'hF;
    liveMask[EN_BIT] = 1'b1;
  end

  assign violNow = busCycleIn && busWriteIn && (|(csActiveIn & csReadOnlyIn));

  AST_WDOG_BERR: assert property (@(posedge clk) disable iff (!rstN)
    wdogTimeoutIn |=> busErrOut); // R5

  AST_WDOG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wdogTimeoutIn |=> statusFlags[2]); // R5

  AST_BERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (busErrOut && !$rose(rstN)) |-> ($past(wdogTimeoutIn) || ($past(violNow) && $past(wpvEnable)))); // R7

  AST_PROTECT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    violNow |=> statusFlags[1]); // R6

  AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (busCycleIn && ($countones(csActiveIn) >= 2)) |=> statusFlags[0]); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    irqPendingIn |=> statusFlags[3]); // R9

  AST_W1C_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWrEn && regByteEn[STAT_LANE] && regWrData[STAT_LSB+3] && !irqPendingIn)
    |=> !statusFlags[3]); // R2

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~liveMask) == '0); // R10

  AST_DESELECT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (regRdData == '0)); // R1

endmodule

bind sysEventReg sysEventRegChk #(
  .DATA_W  (DATA_W),
  .NUM_CS  (NUM_CS),
  .STAT_LSB(STAT_LSB),
  .EN_BIT  (EN_BIT)
) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .irqPendingIn (irqPendingIn),
  .wdogTimeoutIn(wdogTimeoutIn),
  .busCycleIn   (busCycleIn),
  .busWriteIn   (busWriteIn),
  .csActiveIn   (csActiveIn),
  .csReadOnlyIn (csReadOnlyIn),
  .regSel       (regSel),
  .regWrEn      (regWrEn),
  .regByteEn    (regByteEn),
  .regWrData    (regWrData),
  .regRdData    (regRdData),
  .busErrOut    (busErrOut),
  .statusFlags  (statusFlags),
  .wpvEnable    (wpvEnable)
);

// File: tb/test_sysEventReg.sv
module test_sysEventReg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqPendingIn = 1'b0;
  logic        wdogTimeoutIn = 1'b0;
  logic        busCycleIn = 1'b0;
  logic        busWriteIn = 1'b0;
  logic [3:0]  csActiveIn = '0;
  logic [3:0]  csReadOnlyIn = '0;
  logic        regSel = 1'b1;
  logic        regWrEn = 1'b0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        busErrOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference state
  bit [3:0] mFlags = '0;
  bit       mEn = 0;
  bit       mBerr = 0;
  bit       mSel = 1;
  string    phase = "R3 reset";

  always #5 clk = ~clk;

  sysEventReg i_sysEventReg (
    .clk(clk), .rstN(rstN),
    .irqPendingIn(irqPendingIn), .wdogTimeoutIn(wdogTimeoutIn),
    .busCycleIn(busCycleIn), .busWriteIn(busWriteIn),
    .csActiveIn(csActiveIn), .csReadOnlyIn(csReadOnlyIn),
    .regSel(regSel), .regWrEn(regWrEn), .regByteEn(regByteEn),
    .regWrData(regWrData), .regRdData(regRdData), .busErrOut(busErrOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", req, phase, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expWord();
    logic [31:0] w = '0;
    if (mSel) begin
      w[27:24] = mFlags;
      w[8] = mEn;
    end
    return w;
  endfunction

  task automatic compareNow();
    check("R1 R10 read word", regRdData, expWord());
    check("R5 R7 bus error", {31'd0, busErrOut}, {31'd0, mBerr});
  endtask

  // One clock: compare state, drive new inputs, advance the reference
  task automatic cyc(input bit irq, input bit wd, input bit bc, input bit bw,
                     input bit [3:0] cs, input bit [3:0] ro,
                     input bit sel, input bit we, input bit [3:0] be,
                     input bit [31:0] wdat);
    int  active;
    bit  viol, conf;
    bit [3:0] setM, clrM;
    @(negedge clk);
    compareNow();
    irqPendingIn = irq; wdogTimeoutIn = wd; busCycleIn = bc; busWriteIn = bw;
    csActiveIn = cs; csReadOnlyIn = ro; regSel = sel; regWrEn = we;
    regByteEn = be; regWrData = wdat;
    active = 0;
    for (int i = 0; i < 4; i++) if (cs[i]) active++;
    viol = 0;
    for (int i = 0; i < 4; i++) if (bc && bw && cs[i] && ro[i]) viol = 1;
    conf = bc && (active >= 2);
    setM = {irq, wd, viol, conf};
    clrM = (sel && we && be[3]) ? wdat[27:24] : 4'b0;
    mSel = sel;
    mBerr = wd || (viol && mEn);
    if (sel && we && be[1]) mEn = wdat[8];
    for (int i = 0; i < 4; i++) begin
      if (setM[i]) mFlags[i] = 1;
      else if (clrM[i]) mFlags[i] = 0;
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 4'h0, 4'h0, 1, 0, 4'h0, 32'h0);
  endtask

  task automatic regWrite(input bit [3:0] be, input bit [31:0] d);
    cyc(0, 0, 0, 0, 4'h0, 4'h0, 1, 1, be, d);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired [%s]", phase);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 reset read", regRdData, 32'h0);
    check("R3 reset busErr", {31'd0, busErrOut}, 32'h0);
    rstN = 1'b1;

    phase = "R4 irq";
    cyc(1, 0, 0, 0, 4'h0, 4'h0, 1, 0, 4'h0, 32'h0);
    idle();

    phase = "R5 watchdog";
    cyc(0, 1, 0, 0, 4'h0, 4'h0, 1, 0, 4'h0, 32'h0);
    idle();
    cyc(0, 1, 0, 0, 4'h0, 4'h0, 1, 0, 4'h0, 32'h0); // flag already set
    idle();

    phase = "R2 clear with lane off";
    regWrite(4'b0111, 32'hFFFF_FFFF);
    idle();
    phase = "R2 write zeros";
    regWrite(4'b1111, 32'h0);
    phase = "R2 clear two";
    regWrite(4'b1000, 32'h0C00_0000);
    idle();

    phase = "R6 read to ro";
    cyc(0, 0, 1, 0, 4'h2, 4'h2, 1, 0, 4'h0, 32'h0);
    phase = "R6 write ro, enable off";
    cyc(0, 0, 1, 1, 4'h2, 4'h2, 1, 0, 4'h0, 32'h0);
    phase = "R6 write rw region";
    cyc(0, 0, 1, 1, 4'h2, 4'h1, 1, 0, 4'h0, 32'h0);
    idle();

    phase = "R10 enable lane off";
    regWrite(4'b1101, 32'h0000_0100);
    phase = "R10 all ones";
    regWrite(4'b0111, 32'hFFFF_FFFF);
    idle();
    phase = "R7 enabled violation";
    regWrite(4'b1000, 32'h0F00_0000);
    cyc(0, 0, 1, 1, 4'h8, 4'h8, 1, 0, 4'h0, 32'h0);
    idle();
    idle();

    phase = "R8 single cs";
    cyc(0, 0, 1, 0, 4'h4, 4'h0, 1, 0, 4'h0, 32'h0);
    phase = "R8 two cs no cycle";
    cyc(0, 0, 0, 0, 4'h6, 4'h0, 1, 0, 4'h0, 32'h0);
    phase = "R8 two cs";
    cyc(0, 0, 1, 0, 4'h6, 4'h0, 1, 0, 4'h0, 32'h0);
    phase = "R8 all cs";
    regWrite(4'b1000, 32'h0100_0000);
    cyc(0, 0, 1, 0, 4'hF, 4'h0, 1, 0, 4'h0, 32'h0);
    idle();

    phase = "R9 set beats clear";
    cyc(1, 0, 1, 0, 4'h3, 4'h0, 1, 1, 4'b1000, 32'h0F00_0000);
    idle();

    phase = "R1 deselected read";
    cyc(0, 0, 0, 0, 4'h0, 4'h0, 0, 0, 4'h0, 32'h0);
    idle();

    phase = "R3 mid reset";
    @(negedge clk);
    compareNow();
    rstN = 1'b0;
    mFlags = '0; mEn = 0; mBerr = 0;
    #1;
    check("R3 async reset read", regRdData, expWord());
    check("R3 async reset busErr", {31'd0, busErrOut}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    phase = "random R2 R4 R5 R6 R7 R8 R9 R10";
    for (int n = 0; n < 3000; n++) begin
      bit [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1] & r[2], r[3] & r[4] & r[5], r[6], r[7],
          r[11:8], r[15:12], r[16] | r[17], r[18] & r[19], r[23:20],
          {4'h0, r[27:24], 15'h0, r[28], 8'h0});
    end
    idle();
    @(negedge clk);
    compareNow();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule